// File: doc/BRIEF.md
# Vector Lane Insert Unit

This unit executes one kind of instruction: copying a general-purpose (scalar) register value into a single lane of a 128-bit vector register. Each cycle it may receive a 32-bit instruction word with a valid strobe. It decodes the word and reads the scalar source through an external read port. It then merges the low bits of the source into one lane of the destination vector register. The unit holds the 32-entry vector register file itself.

Lane width and lane index are both packed into one 5-bit immediate. The lowest set bit among its low four bits selects the width, and the bits above that bit give the index. The merge changes only the selected lane and leaves every other bit of the destination as it was. Words that do not match the opcode are flagged as not decoded. A zero width selector is flagged as undefined. An instruction issued while the vector unit is disabled is flagged as a trap. None of these three cases writes anything.

Top module: `lane_insert_unit`

## Requirements
- R1: A word matches only when bits 31..21 equal 01001110000 and bits 15..10 equal 000111; a valid non-matching word raises `miss_o` and writes nothing.
- R2: Fields: immediate in bits 20..16, scalar source number in bits 9..5 (driven on `sreg_addr_o`), destination vector register number in bits 4..0.
- R3: When immediate bits 3..0 are all zero, a valid matching word raises `undef_o` and writes nothing, whatever immediate bit 4 holds.
- R4: With s the position of the lowest set bit in immediate bits 3..0, the lane width is 8 << s: 8, 16, 32 or 64 bits.
- R5: The lane index is the unsigned value of immediate bits 4 down to s+1. The low lane-width bits of the source land in destination bits [index*width +: width].
- R6: Every destination bit outside the selected lane keeps its previous value after a write.
- R7: Source number 31 supplies the value zero, whatever the scalar port returns.
- R8: A valid matching defined word with `vec_en_i` low raises `trap_o` and writes nothing. The undefined flag takes priority over the trap flag.
- R9: `wr_o` is high in a cycle with valid high, a match, no undefined flag and no trap. The register file changes on the following clock edge and in no other case. Latency does not depend on the data. All four flags are low when valid is low, and at most one is high at a time.
- R10: A synchronous reset clears all 32 vector registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 32 | Instruction word |
| vec_en_i | input | 1 | Vector unit available |
| sreg_addr_o | output | 5 | Scalar register read address |
| sreg_data_i | input | 64 | Scalar register read data |
| rd_addr_i | input | 5 | Vector register read address |
| rd_data_o | output | 128 | Vector register read data |
| wr_o | output | 1 | Write takes place at the next edge |
| miss_o | output | 1 | Word not decoded |
| undef_o | output | 1 | Undefined encoding |
| trap_o | output | 1 | Trapped because the vector unit is off |

## Verification
The bench walks all 32 immediate values. An error in the lowest-set-bit priority would write the wrong width or offset, and an error in the index slice would move the lane. The bench then reads the register back to catch a merge that clears the neighbouring lanes, which a full-width write would do. Source 31 is paired with a nonzero value on the scalar port, so a design that reads a stored register 31 leaks that value into the lane. Undefined words with bit 4 set, disabled-unit words, and words off by one opcode bit are all issued. Any of these that still wrote would show up as a changed register on the next read.

// File: rtl/lane_insert_unit.sv
module lane_insert_unit #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic            vec_en_i,
  output logic [4:0]      sreg_addr_o,
  input  logic [XLEN-1:0] sreg_data_i,
  input  logic [4:0]      rd_addr_i,
  output logic [VLEN-1:0] rd_data_o,
  output logic            wr_o,
  output logic            miss_o,
  output logic            undef_o,
  output logic            trap_o
);
  localparam int OFSW = $clog2(VLEN);

  logic [VLEN-1:0] vrf [NREG];

  logic [4:0] imm5, rn, rd;
  assign imm5 = insn_i[20:16];
  assign rn   = insn_i[9:5];
  assign rd   = insn_i[4:0];
  assign sreg_addr_o = rn;

  logic hit, bad_sz;
  assign hit    = (insn_i[31:21] == 11'b01001110000) && (insn_i[15:10] == 6'b000111);
  assign bad_sz = (imm5[3:0] == 4'b0000);

  assign miss_o  = valid_i & ~hit;
  assign undef_o = valid_i & hit & bad_sz;
  assign trap_o  = valid_i & hit & ~bad_sz & ~vec_en_i;
  assign wr_o    = valid_i & hit & ~bad_sz & vec_en_i;

  logic [VLEN-1:0] lane_ones, lane_mask, src_sh, merged;
  logic [OFSW-1:0] ofs;
  logic [XLEN-1:0] elem;

  always_comb begin
    lane_ones = '0;
    ofs       = '0;
    casez (imm5[3:0])
      4'b???1: begin lane_ones[7:0]  = '1; ofs = {imm5[4:1], 3'b000};    end
      4'b??10: begin lane_ones[15:0] = '1; ofs = {imm5[4:2], 4'b0000};   end
      4'b?100: begin lane_ones[31:0] = '1; ofs = {imm5[4:3], 5'b00000};  end
      4'b1000: begin lane_ones[63:0] = '1; ofs = {imm5[4],   6'b000000}; end
      default: ;
    endcase
  end

  assign elem      = (rn == 5'd31) ? '0 : sreg_data_i;
  assign lane_mask = lane_ones << ofs;
  assign src_sh    = {{(VLEN-XLEN){1'b0}}, elem} << ofs;
  assign merged    = (vrf[rd] & ~lane_mask) | (src_sh & lane_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) vrf[i] <= '0;
    end else if (wr_o) begin
      vrf[rd] <= merged;
    end
  end

  assign rd_data_o = vrf[rd_addr_i];

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_o, miss_o, undef_o, trap_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |-> !(wr_o || miss_o || undef_o || trap_o));

  assert_trap_only_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (!vec_en_i && insn_i[19:16] != 4'b0000));

  assert_undef_zero_size_R3: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> (insn_i[19:16] == 4'b0000));

  assert_lane_only_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_o && rd_addr_i == rd) |=>
      (!$stable(rd_addr_i) || ((rd_data_o ^ $past(rd_data_o)) & ~$past(lane_mask)) == '0));

  assert_hold_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_o |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));
endmodule

// File: tb/test_lane_insert_unit.sv
`timescale 1ns/1ps
module test_lane_insert_unit;
  logic clk = 0, rst = 1, valid_i = 0, vec_en_i = 1;
  logic [31:0] insn_i = '0;
  logic [4:0] sreg_addr_o, rd_addr_i = '0;
  logic [63:0] sreg_data_i;
  logic [127:0] rd_data_o;
  logic wr_o, miss_o, undef_o, trap_o;

  always #4 clk = ~clk;

  lane_insert_unit i_lane_insert_unit (.*);

  logic [63:0]  sfile [32];
  logic [127:0] model [32];
  int checks = 0, fails = 0;
  string phase = "R5";

  assign sreg_data_i = sfile[sreg_addr_o];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] imm5, input logic [4:0] rn, input logic [4:0] rd);
    return {11'b01001110000, imm5, 6'b000111, rn, rd};
  endfunction

  task automatic step(input bit v, input logic [31:0] w, input bit en, input logic [4:0] raddr);
    bit hit, und, e_miss, e_und, e_trap, e_wr;
    int s, width, idx;
    logic [63:0] el;
    valid_i = v; insn_i = w; vec_en_i = en; rd_addr_i = raddr;
    #1;
    hit = (w[31:21] == 11'b01001110000) && (w[15:10] == 6'b000111);
    und = (w[19:16] == 0);
    e_miss = v && !hit;
    e_und  = v && hit && und;
    e_trap = v && hit && !und && !en;
    e_wr   = v && hit && !und && en;
    check(miss_o == e_miss, "R1", miss_o, e_miss);
    check(undef_o == e_und, "R3", undef_o, e_und);
    check(trap_o == e_trap, "R8", trap_o, e_trap);
    check(wr_o == e_wr, "R9", wr_o, e_wr);
    check(sreg_addr_o == w[9:5], "R2", sreg_addr_o, w[9:5]);
    check(rd_data_o === model[raddr], phase, rd_data_o, model[raddr]);
    @(posedge clk);
    if (e_wr) begin
      s = 0;
      while (!w[16+s]) s++;
      width = 8 << s;
      idx = int'(w[20:16]) >> (s + 1);
      el = (w[9:5] == 31) ? 64'd0 : sfile[w[9:5]];
      for (int b = 0; b < width; b++) model[w[4:0]][idx*width + b] = el[b];
    end
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      sfile[i] = {$urandom, $urandom};
      model[i] = '0;
    end
    sfile[31] = 64'hDEAD_BEEF_CAFE_F00D;
    @(negedge clk); @(negedge clk);
    rst = 0;
    phase = "R10";
    for (int i = 0; i < 32; i++) step(0, '0, 1, 5'(i));
    phase = "R5";
    for (int i = 0; i < 32; i++) begin
      step(1, mk(5'(i), 5'(i % 31), 5'd3), 1, 5'd3);
      step(0, '0, 1, 5'd3);
    end
    phase = "R6";
    step(1, mk(5'b00001, 5'd1, 5'd7), 1, 5'd7);
    step(1, mk(5'b11111, 5'd2, 5'd7), 1, 5'd7);
    step(1, mk(5'b11000, 5'd4, 5'd7), 1, 5'd7);
    step(1, mk(5'b00100, 5'd5, 5'd7), 1, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R7";
    step(1, mk(5'b11000, 5'd31, 5'd7), 1, 5'd7);
    step(1, mk(5'b00010, 5'd31, 5'd7), 1, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R3";
    step(1, mk(5'b10000, 5'd1, 5'd7), 1, 5'd7);
    step(1, mk(5'b00000, 5'd1, 5'd7), 0, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R8";
    step(1, mk(5'b00011, 5'd1, 5'd7), 0, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R1";
    step(1, mk(5'b00001, 5'd1, 5'd7) ^ 32'h0020_0000, 1, 5'd7);
    step(1, mk(5'b00001, 5'd1, 5'd7) ^ 32'h0000_0400, 1, 5'd7);
    step(1, mk(5'b00001, 5'd1, 5'd7) ^ 32'h8000_0000, 1, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R9";
    step(0, mk(5'b00001, 5'd1, 5'd7), 1, 5'd7);
    step(0, '0, 1, 5'd7);
    phase = "R4";
    for (int i = 0; i < 400; i++) begin
      logic [4:0] rd = 5'($urandom);
      logic [31:0] w = ($urandom % 5 == 0) ? $urandom : mk(5'($urandom), 5'($urandom), rd);
      step(($urandom % 5) != 0, w, ($urandom % 10) != 0, rd);
    end
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    phase = "R10";
    for (int i = 0; i < 32; i++) step(0, '0, 1, 5'(i));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule